// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and the calendar date as seven packed-BCD bytes: seconds, minutes, hours (24-hour), day-of-week, day-of-month, month and two-digit year. An external once-per-second enable pulse moves the count forward by one second. Each carry ripples into the next field within the same clock cycle. The day-of-month rollover follows the length of the current month, and February is adjusted for leap years.

A host sets any field through a byte-wide parallel load port. A load cycle takes priority over the second pulse. Bit 7 of the seconds byte is a stop flag. While it is set, the whole count is frozen. Writing the seconds byte also raises a clear strobe so that the external sub-second divider can restart its phase. Day-of-week is a simple 1..7 cycle that steps at midnight and is unrelated to the date. Software decides which number means which weekday.

Top module: `bcd_calendar`

## Requirements
- R1: After synchronous reset the outputs read seconds 00 with the stop flag clear, minutes 00, hours 00, day-of-week 01, date 01, month 01, year 00, and `presc_clr` is low.
- R2: A cycle with `tick` high, no load, and the stop flag clear advances seconds by one in BCD. A cycle with `tick` low and no load changes no output.
- R3: Seconds and minutes roll from 59 to 00 and carry into the next field. Hours roll from 23 to 00.
- R4: The stop flag is bit 7 of the seconds byte and is written by a load with select code 0. While it is 1, `tick` has no effect on any field, and it reads back as bit 7 of `sec_o`.
- R5: Day-of-week advances once when the hours roll over. After 07 it returns to 01, whatever the date.
- R6: The date rolls to 01 and the month advances after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R7: In month 02 the last day is 29 when the BCD year is a multiple of 4, and 28 otherwise.
- R8: Month rolls from 12 to 01 and increments the year. Year rolls from 99 to 00.
- R9: When `ld_en` is high, `ld_sel` picks the field to write: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year. The field shows `ld_data` on the next cycle. Code 7 writes nothing. No field advances in a load cycle, even if `tick` is high.
- R10: `presc_clr` is high exactly in the cycles where `ld_en` is high with `ld_sel` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for the load |
| ld_data | input | 8 | BCD value to load (bit 7 = stop flag for seconds) |
| sec_o | output | 8 | Stop flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 24-hour |
| dow_o | output | 8 | Day-of-week 01..07 |
| date_o | output | 8 | BCD day-of-month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| presc_clr | output | 1 | Sub-second divider clear strobe |

## Verification
A host load and a one-second pulse can arrive in the same cycle. The load must win, and the pulse must be dropped rather than deferred. The bench provokes this with random loads overlaid on a dense random tick stream. It also uses directed cases where a load coincides with a tick while seconds sit at 59. A cycle-level bench model decides which one applies, and the bench compares all seven fields on the next cycle. The stop flag set in the same load path is judged the same way. Ticks that arrive while it is set must leave every field unchanged.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 3;
    localparam int NUM_FIELDS = 7;

    localparam int IX_SEC   = 0;
    localparam int IX_MIN   = 1;
    localparam int IX_HOUR  = 2;
    localparam int IX_DOW   = 3;
    localparam int IX_DATE  = 4;
    localparam int IX_MONTH = 5;
    localparam int IX_YEAR  = 6;

    typedef logic [BYTE_W-1:0] bcd8_t;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        bcd8_t            data;
    } load_req_t;

    typedef enum logic {RUNNING = 1'b0, STOPPED = 1'b1} run_e;

    function automatic bcd8_t bcd_incr(bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic bcd8_t field_floor(int ix);
        if (ix == IX_DOW || ix == IX_DATE || ix == IX_MONTH) return 8'h01;
        return 8'h00;
    endfunction

    function automatic bcd8_t field_ceiling(int ix);
        case (ix)
            IX_SEC, IX_MIN: return 8'h59;
            IX_HOUR:        return 8'h23;
            IX_DOW:         return 8'h07;
            IX_MONTH:       return 8'h12;
            IX_YEAR:        return 8'h99;
            default:        return 8'h31;
        endcase
    endfunction

    // BCD year divisible by 4: even tens -> ones 0/4/8, odd tens -> ones 2/6
    function automatic logic leap_bcd(bcd8_t y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic bcd8_t month_days(bcd8_t m, logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
    import bcd_cal_pkg::*;
#(
    parameter bcd8_t LO  = 8'h00,
    parameter bcd8_t RST = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  inc,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  bcd8_t ceil_val,
    output bcd8_t q
);

    always_ff @(posedge clk) begin
        if (rst)          q <= RST;
        else if (ld)      q <= ld_val;
        else if (inc)     q <= (q == ceil_val) ? LO : bcd_incr(q);
    end

endmodule

// File: rtl/month_length.sv
module month_length
    import bcd_cal_pkg::*;
(
    input  bcd8_t month_i,
    input  bcd8_t year_i,
    output bcd8_t days_o
);

    logic leap;

    always_comb begin
        leap   = leap_bcd(year_i);
        days_o = month_days(month_i, leap);
    end

endmodule

// File: rtl/halt_ctl.sv
module halt_ctl
    import bcd_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  load_req_t req,
    output logic      halted,
    output logic      adv_en,
    output logic      presc_clr
);

    run_e state;
    logic sec_write;

    assign sec_write = req.en && (req.sel == SEL_W'(IX_SEC));

    always_ff @(posedge clk) begin
        if (rst)            state <= RUNNING;
        else if (sec_write) state <= run_e'(req.data[BYTE_W-1]);
    end

    assign halted    = (state == STOPPED);
    assign adv_en    = tick && !halted && !req.en;
    assign presc_clr = sec_write;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [BYTE_W-1:0] ld_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] month_o,
    output logic [BYTE_W-1:0] year_o,
    output logic              presc_clr
);

    load_req_t             req;
    logic                  halted;
    logic                  adv_en;
    bcd8_t                 cnt    [NUM_FIELDS];
    bcd8_t                 ceil_v [NUM_FIELDS];
    bcd8_t                 ld_val [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] ld_hit;
    logic [NUM_FIELDS-1:0] inc;
    bcd8_t                 dim_bcd;
    logic                  c_sec, c_min, c_hour, c_date, c_month;

    assign req = '{en: ld_en, sel: ld_sel, data: ld_data};

    halt_ctl u_halt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req       (req),
        .halted    (halted),
        .adv_en    (adv_en),
        .presc_clr (presc_clr)
    );

    month_length u_mlen (
        .month_i (cnt[IX_MONTH]),
        .year_i  (cnt[IX_YEAR]),
        .days_o  (dim_bcd)
    );

    // carry chain: each field advances when the one below wraps
    assign c_sec   = inc[IX_SEC]   && (cnt[IX_SEC]   == ceil_v[IX_SEC]);
    assign c_min   = inc[IX_MIN]   && (cnt[IX_MIN]   == ceil_v[IX_MIN]);
    assign c_hour  = inc[IX_HOUR]  && (cnt[IX_HOUR]  == ceil_v[IX_HOUR]);
    assign c_date  = inc[IX_DATE]  && (cnt[IX_DATE]  == ceil_v[IX_DATE]);
    assign c_month = inc[IX_MONTH] && (cnt[IX_MONTH] == ceil_v[IX_MONTH]);

    assign inc[IX_SEC]   = adv_en;
    assign inc[IX_MIN]   = c_sec;
    assign inc[IX_HOUR]  = c_min;
    assign inc[IX_DOW]   = c_hour;
    assign inc[IX_DATE]  = c_hour;
    assign inc[IX_MONTH] = c_date;
    assign inc[IX_YEAR]  = c_month;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign ld_hit[i] = req.en && (req.sel == SEL_W'(i));

        if (i == IX_SEC) begin : g_sec_val
            assign ld_val[i] = {1'b0, req.data[BYTE_W-2:0]};
        end else begin : g_plain_val
            assign ld_val[i] = req.data;
        end

        if (i == IX_DATE) begin : g_var_ceil
            assign ceil_v[i] = dim_bcd;
        end else begin : g_fix_ceil
            assign ceil_v[i] = field_ceiling(i);
        end

        bcd_field_ctr #(
            .LO  (field_floor(i)),
            .RST (field_floor(i))
        ) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .inc      (inc[i]),
            .ld       (ld_hit[i]),
            .ld_val   (ld_val[i]),
            .ceil_val (ceil_v[i]),
            .q        (cnt[i])
        );
    end

    assign sec_o   = cnt[IX_SEC] | {halted, {(BYTE_W-1){1'b0}}};
    assign min_o   = cnt[IX_MIN];
    assign hour_o  = cnt[IX_HOUR];
    assign dow_o   = cnt[IX_DOW];
    assign date_o  = cnt[IX_DATE];
    assign month_o = cnt[IX_MONTH];
    assign year_o  = cnt[IX_YEAR];

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
    import bcd_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              ld_en,
    input logic [SEL_W-1:0]  ld_sel,
    input logic [BYTE_W-1:0] ld_data,
    input logic [BYTE_W-1:0] sec_o,
    input logic [BYTE_W-1:0] min_o,
    input logic [BYTE_W-1:0] hour_o,
    input logic [BYTE_W-1:0] dow_o,
    input logic [BYTE_W-1:0] date_o,
    input logic [BYTE_W-1:0] month_o,
    input logic [BYTE_W-1:0] year_o,
    input logic              presc_clr
);

    logic run_tick;
    logic midnight;
    assign run_tick = tick && !ld_en && !sec_o[7];
    assign midnight = run_tick && (sec_o[6:0] == 7'h59) && (min_o == 8'h59) && (hour_o == 8'h23);

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld_en) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o})); // R2

    AST_SEC_ROLL: assert property (@(posedge clk) disable iff (rst)
        (run_tick && sec_o[6:0] == 7'h59) |=> (sec_o[6:0] == 7'h00)); // R3

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sec_o[7] && !ld_en) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o})); // R4

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (midnight && dow_o == 8'h07) |=> (dow_o == 8'h01)); // R5

    AST_LOAD_MIN: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_sel == 3'd1) |=> (min_o == $past(ld_data))); // R9

    AST_CLR_WRITES_SEC: assert property (@(posedge clk) disable iff (rst)
        presc_clr |=> (sec_o == $past(ld_data))); // R10

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       presc_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    bit m_halt;

    always #2.5 clk = ~clk;

    bcd_calendar u_dut (
        .clk(clk), .rst(rst), .tick(tick), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .presc_clr(presc_clr)
    );

    function automatic logic [7:0] b(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int ub(logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] expected();
        return {m_halt, b(m_sec)[6:0], b(m_min), b(m_hr), b(m_dow), b(m_date), b(m_mon), b(m_yr)};
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_halt = 0;
    endtask

    task automatic model_step(bit tk, bit ld, logic [2:0] sel, logic [7:0] d);
        if (ld) begin
            case (sel)
                3'd0: begin m_halt = d[7]; m_sec = ub({1'b0, d[6:0]}); end
                3'd1: m_min  = ub(d);
                3'd2: m_hr   = ub(d);
                3'd3: m_dow  = ub(d);
                3'd4: m_date = ub(d);
                3'd5: m_mon  = ub(d);
                3'd6: m_yr   = ub(d);
                default: ;
            endcase
        end else if (tk && !m_halt) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hr++;
                    if (m_hr == 24) begin
                        m_hr = 0;
                        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                        m_date++;
                        if (m_date > dim(m_mon, m_yr)) begin
                            m_date = 1; m_mon++;
                            if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_outputs(string tag);
        logic [55:0] got, exp;
        got = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
        exp = expected();
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: outputs got %014h expected %014h", tag, got, exp);
        end
    endtask

    // called right after a falling edge; result checked at the next falling edge
    task automatic cycle(bit tk, bit ld, logic [2:0] sel, logic [7:0] d, string tag);
        bit exp_clr;
        tick = tk; ld_en = ld; ld_sel = sel; ld_data = d;
        #1;
        exp_clr = ld && (sel == 3'd0);
        checks++;
        if (presc_clr !== exp_clr) begin
            fails++;
            $display("FAIL R10: presc_clr got %0b expected %0b", presc_clr, exp_clr);
        end
        model_step(tk, ld, sel, d);
        @(negedge clk);
        check_outputs(tag);
        tick = 0; ld_en = 0;
    endtask

    task automatic set_time(int hr, int mi, int s, int dw, int dt, int mo, int yr);
        cycle(0, 1, 3'd6, b(yr), "R9");
        cycle(0, 1, 3'd5, b(mo), "R9");
        cycle(0, 1, 3'd4, b(dt), "R9");
        cycle(0, 1, 3'd3, b(dw), "R9");
        cycle(0, 1, 3'd2, b(hr), "R9");
        cycle(0, 1, 3'd1, b(mi), "R9");
        cycle(0, 1, 3'd0, b(s),  "R9");
    endtask

    task automatic rand_load();
        int f;
        logic [7:0] d;
        f = $urandom_range(0, 6);
        case (f)
            0: d = b($urandom_range(50, 59)) | (($urandom_range(0, 3) == 0) ? 8'h80 : 8'h00);
            1: d = b($urandom_range(57, 59));
            2: d = b($urandom_range(20, 23));
            3: d = b($urandom_range(1, 7));
            4: d = b($urandom_range(dim(m_mon, m_yr) - 1, dim(m_mon, m_yr)));
            5: begin
                if (m_date > 28) begin f = 4; d = b(28); end
                else d = b($urandom_range(1, 12));
            end
            default: begin
                if (m_mon == 2 && m_date == 29) d = b(4 * $urandom_range(0, 24));
                else d = b($urandom_range(0, 99));
            end
        endcase
        cycle($urandom_range(0, 1) == 1, 1, 3'(f), d, "R9");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check_outputs("R1");
        checks++;
        if (presc_clr !== 1'b0) begin
            fails++;
            $display("FAIL R1: presc_clr got %0b expected 0", presc_clr);
        end
        @(negedge clk);

        cycle(0, 0, 3'd0, 8'h00, "R2");
        cycle(1, 0, 3'd0, 8'h00, "R2");
        cycle(1, 0, 3'd0, 8'h00, "R2");

        // full rollover of every field, day-of-week 7 -> 1
        set_time(23, 59, 59, 7, 31, 12, 99);
        cycle(1, 0, 3'd0, 8'h00, "R3 R5 R8");

        // 30-day and 31-day months
        set_time(23, 59, 59, 3, 30, 4, 10);
        cycle(1, 0, 3'd0, 8'h00, "R6");
        set_time(23, 59, 59, 3, 31, 1, 10);
        cycle(1, 0, 3'd0, 8'h00, "R6");

        // February in common and leap years
        set_time(23, 59, 59, 2, 28, 2, 23);
        cycle(1, 0, 3'd0, 8'h00, "R7");
        set_time(23, 59, 59, 2, 28, 2, 24);
        cycle(1, 0, 3'd0, 8'h00, "R7");
        set_time(23, 59, 59, 2, 29, 2, 24);
        cycle(1, 0, 3'd0, 8'h00, "R7");
        set_time(23, 59, 59, 2, 28, 2, 30);
        cycle(1, 0, 3'd0, 8'h00, "R7");

        // stop flag
        cycle(0, 1, 3'd0, 8'h85, "R4");
        for (int k = 0; k < 5; k++) cycle(1, 0, 3'd0, 8'h00, "R4");
        cycle(0, 1, 3'd0, 8'h05, "R4");
        cycle(1, 0, 3'd0, 8'h00, "R4");

        // unused select code, and load colliding with a tick at 59 s
        cycle(1, 1, 3'd7, 8'h42, "R9");
        cycle(0, 1, 3'd0, 8'h59, "R9");
        cycle(1, 1, 3'd1, 8'h30, "R9");
        cycle(1, 0, 3'd0, 8'h00, "R3");

        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 15) == 0) rand_load();
            else cycle($urandom_range(0, 3) != 0, 0, 3'd0, 8'h00, "R2 R3");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule